// File: doc/BRIEF.md
# Constant-Delay TDM Time-Slot Switch

This block exchanges time-slots between a serial TDM input stream and a serial TDM output stream. Every channel arriving on the input is captured into one of three frame banks. Each output slot is then filled from whichever input slot the connection map names for it. The frame counter rotates the banks so that a channel captured during input frame N always leaves during output frame N+2. The throughput delay therefore depends only on the slot positions, never on how the write and read pointers happen to line up.

A frame holds 32, 64 or 128 slots of 8 bits each, picked by a rate input. Bits move MSB first, one per clock. A frame pulse realigns the slot and bit counters. The connection map is loaded through a simple write port. A write lands in a pending copy, and the pending copy becomes active at the next frame start.

Top module: `tdm_cd_switch`

## Requirements
- R1: While reset is low and in the first cycle after its release, `ser_out` is 0. After reset, every connection map entry selects its own slot number (identity map).
- R2: `rate_sel` 0 gives 32 slots per frame, 1 gives 64, and 2 or 3 gives 128. Without any frame pulse, the position counter wraps after the last bit of the last slot and starts a new frame by itself.
- R3: Each slot carries 8 bits, MSB first. `ser_in` is sampled on the rising clock edge. `ser_out` changes only after a rising edge.
- R4: A byte captured in input slot i of frame N appears in frame N+2, in every output slot whose active map entry selects i.
- R5: Each map entry is indexed by output slot and holds a source input slot. Several output slots may select the same source.
- R6: Only the low-order bits of a source number that fit the current frame length are used, so the source is taken modulo the slots per frame.
- R7: A map write sampled on a clock edge that does not end a frame takes effect at the next frame start. The frame in progress is built entirely from the previous map.
- R8: A `frame_pulse` sampled high on a rising edge makes the next cycle bit 0 of slot 0 of a new frame, and advances the bank rotation.
- R9: With 32 slots per frame, input slot 32 to output slot 1 gives a delay of 32 slots, and input slot 1 to output slot 32 gives a delay of 94 slots (slots numbered from 1). Both follow from R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | Frame alignment; the next cycle becomes slot 0, bit 0 |
| rate_sel | input | 2 | Frame length: 0=32, 1=64, 2 or 3=128 slots |
| ser_in | input | 1 | Serial input stream, MSB first |
| ser_out | output | 1 | Serial output stream, MSB first |
| cm_wr_en | input | 1 | Connection map write strobe |
| cm_wr_slot | input | SLOT_AW | Output slot whose map entry is written |
| cm_wr_src | input | SLOT_AW | Source input slot stored in that entry |

## Verification
With the identity map at 32 slots and frame pulses every frame, the bench confirms bit order, the two-frame latency and realignment. A wrong bank choice shows up as data from the wrong frame. A reversed map at 32 slots puts the shortest and longest delays side by side. A broadcast map at 128 slots, with no pulses after the first, shows that several outputs can share one source and that the counter wraps by itself. Out-of-range source numbers at 32 slots check the modulo rule. A map rewritten mid-frame at 64 slots tells an update that waits for the frame boundary apart from one that leaks into the frame in progress.

// File: rtl/tdm_sw_pkg.sv
package tdm_sw_pkg;
  typedef logic [1:0] bufsel_t;
  localparam bufsel_t LAST_BANK = 2'd2;

  // next bank in the three-way rotation
  function automatic bufsel_t bank_after(bufsel_t b);
    return (b >= LAST_BANK) ? 2'd0 : b + 2'd1;
  endfunction

  // bank being read while bank w is written: the one filled two frames ago
  function automatic bufsel_t bank_to_read(bufsel_t w);
    return bank_after(w);
  endfunction

  function automatic int unsigned slots_for_rate(logic [1:0] r);
    case (r)
      2'd0:    return 32;
      2'd1:    return 64;
      default: return 128;
    endcase
  endfunction
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
  import tdm_sw_pkg::*;
#(
  parameter int SLOT_AW = 7,
  parameter int BIT_AW  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_pulse,
  input  logic [1:0]         rate_sel,
  output logic [SLOT_AW-1:0] cur_slot,
  output logic [BIT_AW-1:0]  cur_bit,
  output logic [SLOT_AW-1:0] nxt_slot,
  output logic               slot_end,
  output logic               frame_start,
  output bufsel_t            wbank,
  output bufsel_t            nxt_wbank
);
  localparam int POS_W = SLOT_AW + BIT_AW;

  logic [POS_W-1:0] pos_q, nxt_pos, last_pos;
  bufsel_t          wbank_q;

  assign last_pos    = POS_W'((slots_for_rate(rate_sel) << BIT_AW) - 1);
  assign frame_start = frame_pulse || (pos_q >= last_pos);
  assign nxt_pos     = frame_start ? '0 : pos_q + POS_W'(1);
  assign nxt_wbank   = frame_start ? bank_after(wbank_q) : wbank_q;

  assign cur_slot = pos_q[POS_W-1:BIT_AW];
  assign cur_bit  = pos_q[BIT_AW-1:0];
  assign nxt_slot = nxt_pos[POS_W-1:BIT_AW];
  assign slot_end = &cur_bit;
  assign wbank    = wbank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      wbank_q <= 2'd0;
    end else begin
      pos_q   <= nxt_pos;
      wbank_q <= nxt_wbank;
    end
  end
endmodule

// File: rtl/tdm_frame_store.sv
module tdm_frame_store
  import tdm_sw_pkg::*;
#(
  parameter int CH_W    = 8,
  parameter int SLOT_AW = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_in,
  input  logic               slot_end,
  input  bufsel_t            wr_bank,
  input  logic [SLOT_AW-1:0] wr_slot,
  input  bufsel_t            rd_bank,
  input  logic [SLOT_AW-1:0] rd_slot,
  output logic [CH_W-1:0]    cap_byte,
  output logic [CH_W-1:0]    rd_byte
);
  localparam int NSLOT = 1 << SLOT_AW;
  localparam int NBANK = 3;

  logic [CH_W-2:0] sh_q;
  logic [CH_W-1:0] bank_rd [NBANK];

  assign cap_byte = {sh_q, ser_in};

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= cap_byte[CH_W-2:0];
  end

  // one storage bank per frame of the rotation; contents are not reset
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [CH_W-1:0] cells [NSLOT];
    always_ff @(posedge clk) begin
      if (slot_end && (wr_bank == bufsel_t'(g))) cells[wr_slot] <= cap_byte;
    end
    assign bank_rd[g] = cells[rd_slot];
  end

  assign rd_byte = bank_rd[rd_bank];
endmodule

// File: rtl/tdm_conn_map.sv
module tdm_conn_map #(
  parameter int SLOT_AW = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SLOT_AW-1:0] wr_slot,
  input  logic [SLOT_AW-1:0] wr_src,
  input  logic               commit,
  input  logic [SLOT_AW-1:0] rd_slot,
  output logic [SLOT_AW-1:0] rd_src
);
  localparam int NSLOT = 1 << SLOT_AW;

  logic [SLOT_AW-1:0] pend_q [NSLOT];
  logic [SLOT_AW-1:0] act_q  [NSLOT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) pend_q[i] <= SLOT_AW'(i);
    end else if (wr_en) begin
      pend_q[wr_slot] <= wr_src;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) act_q[i] <= SLOT_AW'(i);
    end else if (commit) begin
      for (int i = 0; i < NSLOT; i++) act_q[i] <= pend_q[i];
    end
  end

  // at a frame start the first slot of the new frame already uses the pending map
  assign rd_src = commit ? pend_q[rd_slot] : act_q[rd_slot];
endmodule

// File: rtl/tdm_cd_switch.sv
module tdm_cd_switch
  import tdm_sw_pkg::*;
#(
  parameter int CH_W    = 8,
  parameter int SLOT_AW = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_pulse,
  input  logic [1:0]         rate_sel,
  input  logic               ser_in,
  output logic               ser_out,
  input  logic               cm_wr_en,
  input  logic [SLOT_AW-1:0] cm_wr_slot,
  input  logic [SLOT_AW-1:0] cm_wr_src
);
  localparam int BIT_AW = $clog2(CH_W);

  logic [SLOT_AW-1:0] cur_slot, nxt_slot, map_src, src_eff, src_mask;
  logic [BIT_AW-1:0]  cur_bit;
  logic               slot_end, frame_start, load_evt;
  bufsel_t            wbank, nxt_wbank, rbank;
  logic [CH_W-1:0]    cap_byte, rd_byte, out_q;

  tdm_frame_timer #(.SLOT_AW(SLOT_AW), .BIT_AW(BIT_AW)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .rate_sel(rate_sel),
    .cur_slot(cur_slot), .cur_bit(cur_bit), .nxt_slot(nxt_slot),
    .slot_end(slot_end), .frame_start(frame_start),
    .wbank(wbank), .nxt_wbank(nxt_wbank)
  );

  tdm_conn_map #(.SLOT_AW(SLOT_AW)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_en(cm_wr_en), .wr_slot(cm_wr_slot),
    .wr_src(cm_wr_src), .commit(frame_start), .rd_slot(nxt_slot), .rd_src(map_src)
  );

  assign src_mask = SLOT_AW'(slots_for_rate(rate_sel) - 1);
  assign src_eff  = map_src & src_mask;
  assign rbank    = bank_to_read(nxt_wbank);

  tdm_frame_store #(.CH_W(CH_W), .SLOT_AW(SLOT_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .slot_end(slot_end),
    .wr_bank(wbank), .wr_slot(cur_slot), .rd_bank(rbank), .rd_slot(src_eff),
    .cap_byte(cap_byte), .rd_byte(rd_byte)
  );

  // next cycle begins a slot: fetch its byte, else keep shifting MSB first
  assign load_evt = slot_end || frame_start;

  always_ff @(posedge clk) begin
    if (!rst_n)        out_q <= '0;
    else if (load_evt) out_q <= rd_byte;
    else               out_q <= {out_q[CH_W-2:0], 1'b0};
  end

  assign ser_out = out_q[CH_W-1];
endmodule

// File: rtl/tdm_cd_switch_chk.sv
module tdm_cd_switch_chk
  import tdm_sw_pkg::*;
#(
  parameter int CH_W    = 8,
  parameter int SLOT_AW = 7,
  parameter int BIT_AW  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_pulse,
  input logic               frame_start,
  input logic               load_evt,
  input logic [SLOT_AW-1:0] cur_slot,
  input logic [BIT_AW-1:0]  cur_bit,
  input bufsel_t            wbank,
  input logic [CH_W-1:0]    out_q,
  input logic               ser_out
);
  a_r1_out_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !ser_out);

  a_r8_pulse_realigns: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> (cur_slot == '0) && (cur_bit == '0));

  a_r2_position_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> {cur_slot, cur_bit} == $past({cur_slot, cur_bit}) + 1'b1);

  a_r4_bank_rotates: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> wbank == bank_after($past(wbank)));

  a_r4_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(wbank));

  a_r3_msb_first_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> ser_out == $past(out_q[CH_W-2]));
endmodule

bind tdm_cd_switch tdm_cd_switch_chk #(.CH_W(CH_W), .SLOT_AW(SLOT_AW), .BIT_AW(BIT_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .frame_start(frame_start),
  .load_evt(load_evt), .cur_slot(cur_slot), .cur_bit(cur_bit), .wbank(wbank),
  .out_q(out_q), .ser_out(ser_out)
);

// File: tb/sim_tdm_cd_switch.sv
`timescale 1ns/1ps
module sim_tdm_cd_switch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_pulse = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       ser_in = 1'b0;
  logic       ser_out;
  logic       cm_wr_en = 1'b0;
  logic [6:0] cm_wr_slot = '0;
  logic [6:0] cm_wr_src = '0;

  always #2 clk = ~clk;

  tdm_cd_switch u0 (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .rate_sel(rate_sel),
    .ser_in(ser_in), .ser_out(ser_out), .cm_wr_en(cm_wr_en),
    .cm_wr_slot(cm_wr_slot), .cm_wr_src(cm_wr_src)
  );

  int n_chk = 0;
  int n_bad = 0;
  int salt  = 0;
  logic [7:0] hist [3][128];
  int m_pend [128];
  int m_act  [128];
  int wq_n = 0;
  int wq_slot [128];
  int wq_src  [128];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int f, input int s);
    return 8'((s * 37) ^ (f * 91) ^ (salt * 13) ^ 8'h5A);
  endfunction

  task automatic start(input logic [1:0] r);
    rate_sel = r; rst_n = 1'b0; frame_pulse = 1'b0; cm_wr_en = 1'b0; ser_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 128; i++) begin m_pend[i] = i; m_act[i] = i; end
    wq_n = 0;
    repeat (13) @(negedge clk);
    frame_pulse = 1'b1;
    @(negedge clk);
    frame_pulse = 1'b0;
  endtask

  // one loop iteration per bit cycle; output frames from the third on are compared
  task automatic run(input int nfr, input int L, input bit pulses,
                     input int wr_frame, input int wr_from, input string req);
    int wi = 0;
    logic [7:0] ob = '0;
    for (int f = 0; f < nfr; f++) begin
      for (int p = 0; p < L * 8; p++) begin
        int s = p / 8;
        int b = p % 8;
        if (p == 0) for (int i = 0; i < 128; i++) m_act[i] = m_pend[i];
        if (b == 0) hist[f % 3][s] = pat(f, s);
        ob[7 - b] = ser_out;
        ser_in = hist[f % 3][s][7 - b];
        if (f == wr_frame && p >= wr_from && wi < wq_n && p < L * 8 - 1) begin
          cm_wr_en = 1'b1; cm_wr_slot = 7'(wq_slot[wi]); cm_wr_src = 7'(wq_src[wi]);
          m_pend[wq_slot[wi]] = wq_src[wi] % 128;
          wi++;
        end else begin
          cm_wr_en = 1'b0;
        end
        frame_pulse = pulses && (p == L * 8 - 1);
        if (b == 7 && f >= 2) begin
          int src = m_act[s] % L;
          logic [7:0] ex = hist[(f + 1) % 3][src];
          if ((s == 0 && src == L - 1) || (s == L - 1 && src == 0))
            check(ob == ex, "R9", ob, ex);
          else
            check(ob == ex, req, ob, ex);
        end
        @(negedge clk);
      end
    end
    frame_pulse = 1'b0; cm_wr_en = 1'b0;
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0; rate_sel = 2'd0;
    repeat (3) @(negedge clk);
    check(ser_out == 1'b0, "R1 out low in reset", ser_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ser_out == 1'b0, "R1 out low after release", ser_out, 0);
  endtask

  // identity map after reset, pulses every frame: R1 map, R3 bit order, R4 latency, R8
  task automatic t_identity_32;
    salt = 1; start(2'd0);
    run(5, 32, 1'b1, -1, 0, "R4 R3 R8 identity 32");
  endtask

  task automatic t_reverse_32;
    salt = 2; start(2'd0);
    for (int j = 0; j < 32; j++) begin wq_slot[j] = j; wq_src[j] = 31 - j; end
    wq_n = 32;
    run(5, 32, 1'b1, 0, 0, "R4 reverse 32");
  endtask

  // rate 3 means 128 slots; only the first pulse, later frames by wrap (R2)
  task automatic t_broadcast_128;
    salt = 3; start(2'd3);
    for (int j = 0; j < 128; j++) begin wq_slot[j] = j; wq_src[j] = (j % 2 == 1) ? 77 : 5; end
    wq_n = 128;
    run(4, 128, 1'b0, 0, 0, "R5 R2 broadcast 128");
  endtask

  task automatic t_mask_32;
    salt = 4; start(2'd0);
    for (int j = 0; j < 32; j++) begin
      wq_slot[j] = j; wq_src[j] = ((j % 3) + 1) * 32 + ((j + 7) % 32);
    end
    wq_n = 32;
    run(4, 32, 1'b1, 0, 0, "R6 source modulo 32");
  endtask

  // map rewritten from slot 10 of frame 3: frame 3 stays on identity, frame 4 on new map
  task automatic t_midframe_64;
    salt = 5; start(2'd1);
    for (int j = 0; j < 64; j++) begin wq_slot[j] = j; wq_src[j] = (j + 20) % 64; end
    wq_n = 64;
    run(6, 64, 1'b1, 3, 80, "R7 R2 update at boundary 64");
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    t_reset_state();
    t_identity_32();
    t_reverse_32();
    t_broadcast_128();
    t_mask_32();
    t_midframe_64();
    summary();
    $finish;
  end
endmodule